// File: doc/BRIEF.md
# Serial EEPROM Slave Model (three-wire, 16-bit words)

This block acts as a synthesizable stand-in for a small serial EEPROM, so that a master which talks the three-wire select/clock/data protocol can be checked against a live target. It samples chip select, serial clock and serial data-in on the system clock. It decodes each instruction and keeps an array of 16-bit words, 2^ADDR_W of them: 64 with six address bits, or 256 with eight. The answer goes out on a single data-out pin.

An instruction opens with a start bit of 1. A two-bit operation code and the word address follow, most significant bit first. Reads return a leading zero and then the word. Programming instructions cover a single word or the whole array. They only act when a write-enable latch is set, and each one that acts starts a busy window of BUSY_CYCLES system clocks. During that window the slave reports its state on data-out whenever it is selected again.

The serial inputs are expected to be synchronous to the system clock already. The serial clock is expected to stay in each phase for at least one system clock.

Top module: `mw_eeprom_slave`

## Requirements
- R1: With chip select high and no instruction in progress, serial-clock rising edges with data-in low are ignored. The first rising edge with data-in high is the start bit. The next 2 bits are the operation code, followed by ADDR_W address bits, all most significant bit first.
- R2: Operation code 10 is read, 01 is write and 11 is erase. Code 00 is an extended instruction chosen by the two top address bits: 11 write-enable, 00 write-disable, 10 erase-all, 01 write-all. The other address bits of an extended instruction are don't-care.
- R3: After the last address bit of a read, data-out is 0. Each following serial-clock rising edge launches the next bit of the addressed word, bit 15 first. The rising edge after bit 0 returns data-out to 0.
- R4: A write takes 16 data bits, most significant first, and stores them in the addressed word.
- R5: An erase sets the addressed word to 0xFFFF and leaves the other words unchanged.
- R6: An erase-all sets every word to 0xFFFF.
- R7: A write-all takes 16 data bits and stores them in every word.
- R8: The write-enable latch is cleared by reset and by write-disable, and set by write-enable. While it is clear, write, erase, erase-all and write-all change no word and start no busy window.
- R9: A programming instruction that acts starts a busy window of BUSY_CYCLES clocks. When chip select is dropped and raised again, data-out is 0 while the window runs and 1 after it ends, until the next start bit. A start bit that arrives while the window runs is not accepted.
- R10: Chip select low at any point abandons a partly received instruction without changing memory, and the slave then waits for a new start bit.
- R11: After reset every word reads 0xFFFF and data-out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the master |
| di | input | 1 | Serial data from the master |
| dout | output | 1 | Serial data / ready status to the master |

## Verification
A wrong decode or bit count shows at the ports within one read. It appears as a missing leading zero, a word shifted by one position, or data that belongs to another address, all visible in the 17 bits that follow the header. A write-enable latch stuck in the wrong state shows up two ways. A locked write leaves the word at 0xFFFF and data-out low on reselect, while an enabled write shows data-out low through the busy window. A busy window that is too short or never ends shows at the first reselect, and again when a read issued during the window is answered.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    MW_READ, MW_WRITE, MW_ERASE, MW_EN, MW_DIS, MW_ERAL, MW_WRAL
  } mw_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_DATA, ST_READ, ST_DONE
  } mw_state_e;

  // Operation code plus the two top address bits select the instruction.
  function automatic mw_cmd_e mw_decode(input logic [1:0] op, input logic [1:0] top);
    mw_cmd_e c;
    unique case (op)
      2'b10:   c = MW_READ;
      2'b01:   c = MW_WRITE;
      2'b11:   c = MW_ERASE;
      default: begin
        unique case (top)
          2'b11:   c = MW_EN;
          2'b00:   c = MW_DIS;
          2'b10:   c = MW_ERAL;
          default: c = MW_WRAL;
        endcase
      end
    endcase
    return c;
  endfunction

  function automatic logic mw_is_prog(input mw_cmd_e c);
    return (c == MW_WRITE) || (c == MW_ERASE) || (c == MW_ERAL) || (c == MW_WRAL);
  endfunction

endpackage

// File: rtl/mw_edge_sampler.sv
module mw_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sk,
  output logic sk_rise
);
  logic sk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sk_q <= 1'b0;
    else        sk_q <= sk;
  end

  assign sk_rise = sk & ~sk_q;
endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int TW = $clog2(BUSY_CYCLES + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (start)       cnt_q <= TW'(BUSY_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_START_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= TW'(BUSY_CYCLES)); // R9
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_one,
  input  logic              we_all,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we_all) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= wdata;
    end else if (we_one) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  AST_ALL_FILL_WORD0: assert property (@(posedge clk) disable iff (!rst_n) we_all |=> mem[0] == $past(wdata)); // R7
  AST_ONE_WORD_LANDS: assert property (@(posedge clk) disable iff (!rst_n) (we_one && !we_all) |=> mem[$past(waddr)] == $past(wdata)); // R4
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);
  import mw_pkg::*;

  localparam int HDR_W = ADDR_W + 2;
  localparam int CNT_W = $clog2(HDR_W + DATA_W + 1);
  localparam logic [DATA_W-1:0] ERASED = '1;

  mw_state_e         st_q;
  mw_cmd_e           cmd_q, cmd_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-1:0]  hdr_q, hdr_nx;
  logic [DATA_W-1:0] dat_q, dat_nx;
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic [DATA_W:0]   rd_sh;
  logic              wen_q, pend_q;

  // Named internal events
  logic sk_rise, busy, hdr_done, dat_done, start_ok;
  logic we_one, we_all;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata, rdata;

  mw_edge_sampler u_samp (.clk(clk), .rst_n(rst_n), .sk(sk), .sk_rise(sk_rise));

  mw_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(we_one | we_all), .busy(busy));

  mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we_one(we_one), .we_all(we_all),
    .waddr(waddr), .wdata(wdata), .raddr(addr_nx), .rdata(rdata));

  assign hdr_nx   = {hdr_q[HDR_W-2:0], di};
  assign dat_nx   = {dat_q[DATA_W-2:0], di};
  assign addr_nx  = hdr_nx[ADDR_W-1:0];
  assign cmd_nx   = mw_decode(hdr_nx[HDR_W-1 -: 2], hdr_nx[ADDR_W-1 -: 2]);
  assign start_ok = cs && sk_rise && (st_q == ST_IDLE) && di && !busy;
  assign hdr_done = cs && sk_rise && (st_q == ST_CMD)  && (cnt_q == CNT_W'(HDR_W - 1));
  assign dat_done = cs && sk_rise && (st_q == ST_DATA) && (cnt_q == CNT_W'(DATA_W - 1));

  assign we_one = wen_q && ((hdr_done && cmd_nx == MW_ERASE) || (dat_done && cmd_q == MW_WRITE));
  assign we_all = wen_q && ((hdr_done && cmd_nx == MW_ERAL)  || (dat_done && cmd_q == MW_WRAL));
  assign waddr  = dat_done ? addr_q : addr_nx;
  assign wdata  = dat_done ? dat_nx : ERASED;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cmd_q  <= MW_READ;
      cnt_q  <= '0;
      hdr_q  <= '0;
      dat_q  <= '0;
      addr_q <= '0;
      rd_sh  <= '0;
      wen_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (!cs) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (sk_rise) begin
      unique case (st_q)
        ST_IDLE: if (start_ok) begin
          st_q   <= ST_CMD;
          cnt_q  <= '0;
          pend_q <= 1'b0;
        end
        ST_CMD: begin
          hdr_q <= hdr_nx;
          cnt_q <= cnt_q + 1'b1;
          if (hdr_done) begin
            cnt_q  <= '0;
            cmd_q  <= cmd_nx;
            addr_q <= addr_nx;
            unique case (cmd_nx)
              MW_READ:  begin rd_sh <= {1'b0, rdata}; st_q <= ST_READ; end
              MW_WRITE, MW_WRAL: st_q <= ST_DATA;
              MW_EN:    begin wen_q <= 1'b1; st_q <= ST_DONE; end
              MW_DIS:   begin wen_q <= 1'b0; st_q <= ST_DONE; end
              default:  begin
                st_q <= ST_DONE;
                if (wen_q) pend_q <= 1'b1;
              end
            endcase
          end
        end
        ST_DATA: begin
          dat_q <= dat_nx;
          cnt_q <= cnt_q + 1'b1;
          if (dat_done) begin
            st_q <= ST_DONE;
            if (wen_q) pend_q <= 1'b1;
          end
        end
        ST_READ: rd_sh <= {rd_sh[DATA_W-1:0], 1'b0};
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_READ: dout = rd_sh[DATA_W];
      ST_IDLE: dout = cs && pend_q && !busy;
      default: dout = 1'b0;
    endcase
  end

  AST_ABORT_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) !cs |=> st_q == ST_IDLE); // R10
  AST_READ_LEADS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_READ && $past(st_q) != ST_READ) |-> !dout); // R3
  AST_LOCKED_NO_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> wen_q); // R8
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (busy && st_q == ST_IDLE) |=> st_q != ST_CMD); // R9
  AST_ONE_PORT_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({we_one, we_all})); // R6
  AST_PROG_ONLY_WHEN_DECODED: assert property (@(posedge clk) disable iff (!rst_n) (we_one || we_all) |-> (hdr_done ? mw_is_prog(cmd_nx) : mw_is_prog(cmd_q))); // R2
endmodule

// File: tb/mw_eeprom_slave_bench.sv
module mw_eeprom_slave_bench;
  localparam int AW = 6;
  localparam int BUSY = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mw_eeprom_slave #(.ADDR_W(AW), .DATA_W(16), .BUSY_CYCLES(BUSY)) u_mw_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one serial clock: 4 system clocks low, 4 high; returns with sk just lowered
  task automatic pulse(input logic b);
    @(negedge clk); di = b; sk = 1'b0;
    repeat (3) @(negedge clk);
    sk = 1'b1;
    repeat (4) @(negedge clk);
    sk = 1'b0;
  endtask

  task automatic deselect();
    @(negedge clk); cs = 1'b0; sk = 1'b0; di = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic header(input logic [1:0] op, input logic [AW-1:0] a);
    @(negedge clk); cs = 1'b1;
    pulse(1'b1);
    pulse(op[1]); pulse(op[0]);
    for (int i = AW - 1; i >= 0; i--) pulse(a[i]);
  endtask

  task automatic send_data(input logic [15:0] d, input int nbits);
    for (int i = 15; i > 15 - nbits; i--) pulse(d[i]);
  endtask

  task automatic read_word(input logic [AW-1:0] a, input logic [15:0] exp, input string req);
    logic [15:0] w;
    header(2'b10, a);
    check("R3 dummy zero", {15'd0, dout}, 16'd0);
    for (int i = 15; i >= 0; i--) begin
      pulse(1'b0);
      w[i] = dout;
    end
    check(req, w, exp);
    pulse(1'b0);
    check("R3 trailing low", {15'd0, dout}, 16'd0);
    deselect();
  endtask

  // reselect; acted=1 means the busy window must be seen, then ready
  task automatic status(input bit acted, input string req);
    @(negedge clk); cs = 1'b1;
    @(negedge clk);
    check({req, " status early"}, {15'd0, dout}, 16'd0);
    repeat (BUSY + 5) @(negedge clk);
    check({req, " status late"}, {15'd0, dout}, {15'd0, acted});
    deselect();
  endtask

  task automatic t_reset();
    check("R11 dout after reset", {15'd0, dout}, 16'd0);
    read_word(6'd0, 16'hFFFF, "R11 word 0");
    read_word(6'd63, 16'hFFFF, "R11 word 63");
  endtask

  task automatic t_locked();
    header(2'b01, 6'd5); send_data(16'h1234, 16); deselect();
    status(1'b0, "R8 locked write no busy");
    read_word(6'd5, 16'hFFFF, "R8 locked write ignored");
  endtask

  task automatic t_write();
    header(2'b00, 6'b110000); deselect();            // R2 write-enable
    header(2'b01, 6'd5); send_data(16'hA5C3, 16); deselect();
    status(1'b1, "R9 write busy");
    read_word(6'd5, 16'hA5C3, "R4 write word 5");
    header(2'b01, 6'd9); send_data(16'h0F0F, 16); deselect();
    status(1'b1, "R9 second write");
    read_word(6'd9, 16'h0F0F, "R4 write word 9");
  endtask

  task automatic t_noise();
    @(negedge clk); cs = 1'b1;
    repeat (5) pulse(1'b0);                           // R1 zeros before start ignored
    read_word(6'd5, 16'hA5C3, "R1 leading zeros ignored");
  endtask

  task automatic t_busy_reject();
    header(2'b01, 6'd9); send_data(16'h0F0F, 16); deselect();
    header(2'b10, 6'd5);                              // would read A5C3 if accepted
    pulse(1'b0);
    check("R9 start ignored while busy", {15'd0, dout}, 16'd0);
    deselect();
    repeat (BUSY + 5) @(negedge clk);
  endtask

  task automatic t_abort();
    header(2'b01, 6'd5); send_data(16'h0000, 8); deselect();
    status(1'b0, "R10 abort no busy");
    read_word(6'd5, 16'hA5C3, "R10 aborted write");
  endtask

  task automatic t_erase();
    header(2'b11, 6'd5); deselect();
    status(1'b1, "R9 erase busy");
    read_word(6'd5, 16'hFFFF, "R5 erased word");
    read_word(6'd9, 16'h0F0F, "R5 neighbour kept");
  endtask

  task automatic t_wral();
    header(2'b00, 6'b010000); send_data(16'h3C5A, 16); deselect();
    status(1'b1, "R9 write-all busy");
    read_word(6'd0, 16'h3C5A, "R7 word 0");
    read_word(6'd37, 16'h3C5A, "R7 word 37");
    read_word(6'd63, 16'h3C5A, "R7 word 63");
  endtask

  task automatic t_eral();
    header(2'b00, 6'b100000); deselect();
    status(1'b1, "R9 erase-all busy");
    read_word(6'd0, 16'hFFFF, "R6 word 0");
    read_word(6'd9, 16'hFFFF, "R6 word 9");
  endtask

  task automatic t_disable();
    header(2'b00, 6'b000000); deselect();            // R2 write-disable
    header(2'b01, 6'd7); send_data(16'h0000, 16); deselect();
    status(1'b0, "R8 disabled no busy");
    read_word(6'd7, 16'hFFFF, "R8 write after disable");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_write();
    t_noise();
    t_busy_reject();
    t_abort();
    t_erase();
    t_wral();
    t_eral();
    t_disable();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule